// File: doc/BRIEF.md
# Banked Second Translation Base Register

This block holds the second first-level translation table base used by a memory management unit. It keeps two copies, one for secure state and one for non-secure state. The processor reaches it through a coprocessor register access: a strobe, a read or write direction, and four opcode and register-number fields. It also receives the current privilege level and security state. When the fields select this register, a privileged access reads or writes the copy that belongs to the current security state. A user-mode access raises an undefined-instruction flag and changes nothing.

A write keeps the table base from the upper word bits, which aligns the table to a 16KB boundary. It also keeps two table-walk attributes: shared versus non-shared memory, and inner cacheable versus inner non-cacheable. The error-correction enable bit is fixed at zero, and the reserved bits are not stored. Both copies are driven out at all times so that a page table walker can pick the one it needs.

Reset is taken asynchronously and is released through an internal synchronizer.

Top module: `xlat_base_bank`

## Requirements
- R1: `acc_hit` is 1, in the same cycle, exactly when `acc_valid` is 1 and the fields are `acc_op1`=0, `acc_crn`=2, `acc_crm`=0 and `acc_op2`=1.
- R2: A privileged write (`acc_is_read`=0, `cpu_priv`=1) in secure state (`cpu_nonsec`=0) loads the secure copy on the next clock edge. The base comes from `acc_wdata[31:14]`, shared from bit 1 and cacheable from bit 0. The non-secure copy does not change.
- R3: A privileged write in non-secure state (`cpu_nonsec`=1) loads the non-secure copy in the same way, and the secure copy does not change.
- R4: A privileged read (`acc_is_read`=1) returns the copy of the current security state in the same cycle. `acc_rdata[31:14]` is the base, bit 1 is shared and bit 0 is cacheable.
- R5: `acc_rdata[13:2]` always reads zero. The error-correction bit (bit 2) and the reserved bits are ignored on writes, and `sec_ecc` and `ns_ecc` are always 0.
- R6: A user-mode access (`cpu_priv`=0) that selects this register drives `acc_undef`=1 in the same cycle. It returns `acc_rdata`=0 and leaves both copies unchanged.
- R7: An access whose fields do not select this register leaves both copies unchanged and drives `acc_undef`=0 and `acc_rdata`=0.
- R8: After reset, both copies hold base 0, shared 0 and cacheable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Coprocessor access strobe |
| acc_is_read | input | 1 | 1 = register to core transfer, 0 = core to register |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| cpu_priv | input | 1 | 1 = privileged mode |
| cpu_nonsec | input | 1 | 1 = non-secure state |
| acc_hit | output | 1 | Access selects this register |
| acc_undef | output | 1 | Undefined-instruction flag |
| acc_rdata | output | 32 | Read data, zero unless a privileged read hits |
| sec_base | output | 18 | Secure table base |
| sec_shared | output | 1 | Secure walk shared attribute |
| sec_cacheable | output | 1 | Secure walk inner cacheable attribute |
| sec_ecc | output | 1 | Secure error-correction enable, fixed 0 |
| ns_base | output | 18 | Non-secure table base |
| ns_shared | output | 1 | Non-secure walk shared attribute |
| ns_cacheable | output | 1 | Non-secure walk inner cacheable attribute |
| ns_ecc | output | 1 | Non-secure error-correction enable, fixed 0 |

## Verification
The bench builds the block with its default parameters: 32-bit data, the base starting at bit 14, and field widths of 3, 4, 4 and 3 bits. With these widths the whole 16384-point field space is small enough to sweep with privileged writes, so every address that does not match is shown to leave both copies alone. Walking-bit write patterns in both security states expose any swapped bank or misplaced bit. User-mode reads and writes in both states cover the undefined path.

// File: rtl/xbr_pkg.sv
`timescale 1ns/1ps
package xbr_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_UNDEF = 2'd3
  } acc_kind_t;

  localparam int BANK_SEC = 0;
  localparam int BANK_NS  = 1;
  localparam int N_BANKS  = 2;

  localparam int ATTR_C_BIT = 0;
  localparam int ATTR_S_BIT = 1;
  localparam int ATTR_P_BIT = 2;

endpackage

// File: rtl/xbr_rst_sync.sv
`timescale 1ns/1ps
module xbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/xbr_decode.sv
`timescale 1ns/1ps
module xbr_decode
  import xbr_pkg::*;
#(
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP1_W-1:0] OP1_SEL = '0,
  parameter logic [CRN_W-1:0] CRN_SEL = CRN_W'(2),
  parameter logic [CRM_W-1:0] CRM_SEL = '0,
  parameter logic [OP2_W-1:0] OP2_SEL = OP2_W'(1)
) (
  input  logic             valid,
  input  logic             is_read,
  input  logic             priv,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit,
  output acc_kind_t        kind
);

  logic field_match;

  always_comb begin
    field_match = (op1 == OP1_SEL) && (crn == CRN_SEL) &&
                  (crm == CRM_SEL) && (op2 == OP2_SEL);
    hit = valid && field_match;
    if (!hit) begin
      kind = ACC_NONE;
    end else if (!priv) begin
      kind = ACC_UNDEF;
    end else if (is_read) begin
      kind = ACC_READ;
    end else begin
      kind = ACC_WRITE;
    end
  end

endmodule

// File: rtl/xbr_bank.sv
`timescale 1ns/1ps
module xbr_bank #(
  parameter int BASE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              wr_shared,
  input  logic              wr_cacheable,
  output logic [BASE_W-1:0] base,
  output logic              shared,
  output logic              cacheable
);

  logic [BASE_W-1:0] base_q, base_d;
  logic              shared_q, shared_d;
  logic              cache_q, cache_d;

  always_comb begin
    base_d   = base_q;
    shared_d = shared_q;
    cache_d  = cache_q;
    if (wr_en) begin
      base_d   = wr_base;
      shared_d = wr_shared;
      cache_d  = wr_cacheable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      shared_q <= 1'b0;
      cache_q  <= 1'b0;
    end else if (wr_en) begin
      base_q   <= base_d;
      shared_q <= shared_d;
      cache_q  <= cache_d;
    end
  end

  assign base      = base_q;
  assign shared    = shared_q;
  assign cacheable = cache_q;

endmodule

// File: rtl/xlat_base_bank.sv
`timescale 1ns/1ps
module xlat_base_bank
  import xbr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 14,
  parameter int OP1_W    = 3,
  parameter int CRN_W    = 4,
  parameter int CRM_W    = 4,
  parameter int OP2_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_is_read,
  input  logic [OP1_W-1:0]           acc_op1,
  input  logic [CRN_W-1:0]           acc_crn,
  input  logic [CRM_W-1:0]           acc_crm,
  input  logic [OP2_W-1:0]           acc_op2,
  input  logic [DATA_W-1:0]          acc_wdata,
  input  logic                       cpu_priv,
  input  logic                       cpu_nonsec,
  output logic                       acc_hit,
  output logic                       acc_undef,
  output logic [DATA_W-1:0]          acc_rdata,
  output logic [DATA_W-BASE_LSB-1:0] sec_base,
  output logic                       sec_shared,
  output logic                       sec_cacheable,
  output logic                       sec_ecc,
  output logic [DATA_W-BASE_LSB-1:0] ns_base,
  output logic                       ns_shared,
  output logic                       ns_cacheable,
  output logic                       ns_ecc
);

  localparam int BASE_W = DATA_W - BASE_LSB;

  logic      rst_sync_n;
  acc_kind_t acc_kind;

  logic [BASE_W-1:0] bank_base  [N_BANKS];
  logic              bank_sh    [N_BANKS];
  logic              bank_c     [N_BANKS];
  logic              bank_wr_en [N_BANKS];

  logic              sel_bank;
  logic [BASE_W-1:0] sel_base;
  logic              sel_sh;
  logic              sel_c;
  logic              wdata_unused;

  assign wdata_unused = ^acc_wdata[BASE_LSB-1:ATTR_P_BIT];

  xbr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xbr_decode #(
    .OP1_W (OP1_W),
    .CRN_W (CRN_W),
    .CRM_W (CRM_W),
    .OP2_W (OP2_W)
  ) u_dec (
    .valid   (acc_valid),
    .is_read (acc_is_read),
    .priv    (cpu_priv),
    .op1     (acc_op1),
    .crn     (acc_crn),
    .crm     (acc_crm),
    .op2     (acc_op2),
    .hit     (acc_hit),
    .kind    (acc_kind)
  );

  assign sel_bank = cpu_nonsec;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_wr_en[b] = (acc_kind == ACC_WRITE) && (sel_bank == 1'(b));

    xbr_bank #(.BASE_W(BASE_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .wr_en        (bank_wr_en[b]),
      .wr_base      (acc_wdata[DATA_W-1:BASE_LSB]),
      .wr_shared    (acc_wdata[ATTR_S_BIT]),
      .wr_cacheable (acc_wdata[ATTR_C_BIT]),
      .base         (bank_base[b]),
      .shared       (bank_sh[b]),
      .cacheable    (bank_c[b])
    );
  end

  always_comb begin
    sel_base = bank_base[BANK_SEC];
    sel_sh   = bank_sh[BANK_SEC];
    sel_c    = bank_c[BANK_SEC];
    if (sel_bank) begin
      sel_base = bank_base[BANK_NS];
      sel_sh   = bank_sh[BANK_NS];
      sel_c    = bank_c[BANK_NS];
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_kind == ACC_READ) begin
      acc_rdata[DATA_W-1:BASE_LSB] = sel_base;
      acc_rdata[ATTR_S_BIT]        = sel_sh;
      acc_rdata[ATTR_C_BIT]        = sel_c;
    end
  end

  assign acc_undef = (acc_kind == ACC_UNDEF);

  assign sec_base      = bank_base[BANK_SEC];
  assign sec_shared    = bank_sh[BANK_SEC];
  assign sec_cacheable = bank_c[BANK_SEC];
  assign sec_ecc       = 1'b0;
  assign ns_base       = bank_base[BANK_NS];
  assign ns_shared     = bank_sh[BANK_NS];
  assign ns_cacheable  = bank_c[BANK_NS];
  assign ns_ecc        = 1'b0;

endmodule

// File: rtl/xlat_base_bank_chk.sv
`timescale 1ns/1ps
module xlat_base_bank_chk #(
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 14
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       acc_valid,
  input logic                       acc_is_read,
  input logic [DATA_W-1:0]          acc_wdata,
  input logic                       cpu_priv,
  input logic                       cpu_nonsec,
  input logic                       acc_hit,
  input logic                       acc_undef,
  input logic [DATA_W-1:0]          acc_rdata,
  input logic [DATA_W-BASE_LSB-1:0] sec_base,
  input logic                       sec_shared,
  input logic                       sec_cacheable,
  input logic [DATA_W-BASE_LSB-1:0] ns_base,
  input logic                       ns_shared,
  input logic                       ns_cacheable
);

  logic wr_ok;
  logic rd_ok;
  logic user_hit;

  assign wr_ok    = acc_valid && acc_hit && cpu_priv && !acc_is_read;
  assign rd_ok    = acc_valid && acc_hit && cpu_priv && acc_is_read;
  assign user_hit = acc_valid && acc_hit && !cpu_priv;

  assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ok && !cpu_nonsec) |=>
      (sec_base == $past(acc_wdata[DATA_W-1:BASE_LSB])) &&
      (sec_shared == $past(acc_wdata[1])) &&
      (sec_cacheable == $past(acc_wdata[0])) &&
      $stable(ns_base) && $stable(ns_shared) && $stable(ns_cacheable));

  assert_ns_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ok && cpu_nonsec) |=>
      (ns_base == $past(acc_wdata[DATA_W-1:BASE_LSB])) &&
      (ns_shared == $past(acc_wdata[1])) &&
      (ns_cacheable == $past(acc_wdata[0])) &&
      $stable(sec_base) && $stable(sec_shared) && $stable(sec_cacheable));

  assert_read_bank_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_ok |->
      (acc_rdata[DATA_W-1:BASE_LSB] == (cpu_nonsec ? ns_base : sec_base)) &&
      (acc_rdata[1] == (cpu_nonsec ? ns_shared : sec_shared)) &&
      (acc_rdata[0] == (cpu_nonsec ? ns_cacheable : sec_cacheable)));

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |-> (acc_rdata[BASE_LSB-1:2] == '0));

  assert_user_undef_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    user_hit |-> (acc_undef && (acc_rdata == '0)));

  assert_user_nochg_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    user_hit |=> ($stable(sec_base) && $stable(sec_shared) && $stable(sec_cacheable) &&
                  $stable(ns_base) && $stable(ns_shared) && $stable(ns_cacheable)));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_hit |-> (!acc_undef && (acc_rdata == '0)));

  assert_miss_nochg_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_hit |=> ($stable(sec_base) && $stable(sec_shared) && $stable(sec_cacheable) &&
                  $stable(ns_base) && $stable(ns_shared) && $stable(ns_cacheable)));

endmodule

bind xlat_base_bank xlat_base_bank_chk #(
  .DATA_W   (DATA_W),
  .BASE_LSB (BASE_LSB)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .acc_valid     (acc_valid),
  .acc_is_read   (acc_is_read),
  .acc_wdata     (acc_wdata),
  .cpu_priv      (cpu_priv),
  .cpu_nonsec    (cpu_nonsec),
  .acc_hit       (acc_hit),
  .acc_undef     (acc_undef),
  .acc_rdata     (acc_rdata),
  .sec_base      (sec_base),
  .sec_shared    (sec_shared),
  .sec_cacheable (sec_cacheable),
  .ns_base       (ns_base),
  .ns_shared     (ns_shared),
  .ns_cacheable  (ns_cacheable)
);

// File: tb/xlat_base_bank_bench.sv
`timescale 1ns/1ps
module xlat_base_bank_bench;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_is_read;
  logic [2:0]  acc_op1;
  logic [3:0]  acc_crn;
  logic [3:0]  acc_crm;
  logic [2:0]  acc_op2;
  logic [31:0] acc_wdata;
  logic        cpu_priv;
  logic        cpu_nonsec;
  logic        acc_hit;
  logic        acc_undef;
  logic [31:0] acc_rdata;
  logic [17:0] sec_base;
  logic        sec_shared;
  logic        sec_cacheable;
  logic        sec_ecc;
  logic [17:0] ns_base;
  logic        ns_shared;
  logic        ns_cacheable;
  logic        ns_ecc;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [17:0] m_base [2];
  logic        m_sh   [2];
  logic        m_c    [2];

  logic        s_hit;
  logic        s_undef;
  logic [31:0] s_rdata;

  xlat_base_bank u_xlat_base_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_is_read   (acc_is_read),
    .acc_op1       (acc_op1),
    .acc_crn       (acc_crn),
    .acc_crm       (acc_crm),
    .acc_op2       (acc_op2),
    .acc_wdata     (acc_wdata),
    .cpu_priv      (cpu_priv),
    .cpu_nonsec    (cpu_nonsec),
    .acc_hit       (acc_hit),
    .acc_undef     (acc_undef),
    .acc_rdata     (acc_rdata),
    .sec_base      (sec_base),
    .sec_shared    (sec_shared),
    .sec_cacheable (sec_cacheable),
    .sec_ecc       (sec_ecc),
    .ns_base       (ns_base),
    .ns_shared     (ns_shared),
    .ns_cacheable  (ns_cacheable),
    .ns_ecc        (ns_ecc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(input logic [17:0] b, input logic s, input logic c);
    return {b, 12'h000, s, c};
  endfunction

  task automatic access(input bit rd, input bit ns, input bit pv, input logic [2:0] o1,
                        input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2,
                        input logic [31:0] wd);
    @(negedge clk);
    acc_valid   = 1'b1;
    acc_is_read = rd;
    cpu_nonsec  = ns;
    cpu_priv    = pv;
    acc_op1     = o1;
    acc_crn     = n;
    acc_crm     = m;
    acc_op2     = o2;
    acc_wdata   = wd;
    #1;
    s_hit   = acc_hit;
    s_undef = acc_undef;
    s_rdata = acc_rdata;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    if (pv && !rd && o1 == 3'd0 && n == 4'd2 && m == 4'd0 && o2 == 3'd1) begin
      m_base[ns] = wd[31:14];
      m_sh[ns]   = wd[1];
      m_c[ns]    = wd[0];
    end
  endtask

  task automatic check_state(input string tag);
    check(fmt(sec_base, sec_shared, sec_cacheable) == fmt(m_base[0], m_sh[0], m_c[0]),
          {tag, " secure copy"}, fmt(sec_base, sec_shared, sec_cacheable),
          fmt(m_base[0], m_sh[0], m_c[0]));
    check(fmt(ns_base, ns_shared, ns_cacheable) == fmt(m_base[1], m_sh[1], m_c[1]),
          {tag, " non-secure copy"}, fmt(ns_base, ns_shared, ns_cacheable),
          fmt(m_base[1], m_sh[1], m_c[1]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_is_read = 1'b0; cpu_priv = 1'b0; cpu_nonsec = 1'b0;
    acc_op1 = '0; acc_crn = '0; acc_crm = '0; acc_op2 = '0; acc_wdata = '0;
    for (int b = 0; b < 2; b++) begin
      m_base[b] = '0; m_sh[b] = 1'b0; m_c[b] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8: reset values
    @(negedge clk);
    check_state("R8 reset");
    check({sec_ecc, ns_ecc} == 2'b00, "R8 R5 ecc at reset", {30'd0, sec_ecc, ns_ecc}, 32'd0);

    // R1 and R7: full sweep of the field space with privileged writes
    for (int i = 0; i < 16384; i++) begin
      logic [31:0] wd;
      bit exp_hit;
      wd = {i[13:0], ~i[13:0], i[3:0]} ^ 32'h5A5A_A5A5;
      exp_hit = (i[13:11] == 3'd0) && (i[10:7] == 4'd2) && (i[6:3] == 4'd0) && (i[2:0] == 3'd1);
      access(1'b0, i[0] ^ i[5], 1'b1, i[13:11], i[10:7], i[6:3], i[2:0], wd);
      check(s_hit == exp_hit, "R1 decode", {31'd0, s_hit}, {31'd0, exp_hit});
      check(s_undef == 1'b0 && s_rdata == 32'd0, "R7 quiet on write", s_rdata, 32'd0);
      @(negedge clk);
      check_state("R7 R2 R3 sweep");
    end

    // R2 R3 R4 R5: walking bit patterns in both states
    for (int k = 0; k < 32; k++) begin
      logic [31:0] pat;
      pat = (32'd1 << k) | 32'h0000_0001;
      access(1'b0, 1'b0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, pat);
      access(1'b0, 1'b1, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, ~pat);
      @(negedge clk);
      check_state("R2 R3 walk");
      access(1'b1, 1'b0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, 32'd0);
      check(s_rdata == fmt(m_base[0], m_sh[0], m_c[0]), "R4 R5 secure read", s_rdata,
            fmt(m_base[0], m_sh[0], m_c[0]));
      access(1'b1, 1'b1, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, 32'd0);
      check(s_rdata == fmt(m_base[1], m_sh[1], m_c[1]), "R4 R5 non-secure read", s_rdata,
            fmt(m_base[1], m_sh[1], m_c[1]));
    end

    // R5: all-ones write keeps bits 13:2 zero
    access(1'b0, 1'b0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, 32'hFFFF_FFFF);
    access(1'b1, 1'b0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd1, 32'd0);
    check(s_rdata == 32'hFFFF_C003, "R5 reserved and P read zero", s_rdata, 32'hFFFF_C003);
    check({sec_ecc, ns_ecc} == 2'b00, "R5 ecc outputs", {30'd0, sec_ecc, ns_ecc}, 32'd0);

    // R6: user mode reads and writes in both states
    for (int u = 0; u < 4; u++) begin
      access(u[0], u[1], 1'b0, 3'd0, 4'd2, 4'd0, 3'd1, 32'h1234_4003);
      check(s_undef == 1'b1, "R6 undef flag", {31'd0, s_undef}, 32'd1);
      check(s_rdata == 32'd0, "R6 user read data", s_rdata, 32'd0);
      @(negedge clk);
      check_state("R6 user no change");
    end

    // R7: privileged read of a neighbouring address
    access(1'b1, 1'b0, 1'b1, 3'd0, 4'd2, 4'd0, 3'd0, 32'd0);
    check(s_rdata == 32'd0 && !s_undef && !s_hit, "R7 miss read", s_rdata, 32'd0);
    access(1'b1, 1'b1, 1'b0, 3'd1, 4'd2, 4'd0, 3'd1, 32'd0);
    check(!s_undef && s_rdata == 32'd0, "R7 user miss no undef", {31'd0, s_undef}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule